// File: doc/BRIEF.md
# Reset and Idle Power Controller

This block sits next to a small 8-bit processor core and owns its reset and low-power behaviour. A raw reset request arriving from a board pin is first brought into the clock domain, then counted. The block accepts it only once it has stayed active for a full qualification window of oscillator clocks, so short glitches never reset the core. The window is counted in oscillator clocks and does not depend on whether the core runs six or twelve clocks per machine cycle. A request from the watchdog timer is stretched into a fixed-length pulse that the block drives onto the shared board reset line. Either source then asserts the internal system reset.

The block also keeps a two-bit power control register that the core writes. One bit selects idle, where only the core clock stops, and the other selects power-down, where the peripheral clock also stops. Setting both bits together selects power-down. A pending, already-enabled interrupt ends idle. Power-down ends only on an external wake input or an accepted reset, and it never drops into idle afterwards. The two clock enables and a one-clock interrupt-vector request come out as registered signals.

Top module: `rst_pwr_ctrl`

## Requirements
- R1: The reset pin input passes through a two-flop synchronizer and is accepted only after the synchronized level has been high for QUAL_CLKS (24) consecutive clocks. A pin pulse of N clocks with N < 24 never raises sys_rst.
- R2: For an accepted pin pulse of N >= 24 clocks, sys_rst is high for exactly N - 22 clocks. This covers the whole qualified stretch plus one trailing clock.
- R3: A one-clock wdt_req while rst_drive is low makes rst_drive high for exactly WDT_LEN (96) consecutive clocks, starting on the clock after the request. A request made while rst_drive is high is ignored.
- R4: A watchdog pulse also raises sys_rst, for WDT_LEN + 1 (97) clocks.
- R5: In run mode (pcon_q = 00), a pcon_wr with pcon_wdata bit0 = 1 and bit1 = 0 loads pcon_q = 01 (idle) on that clock edge. After that edge cpu_clk_en is 0 and per_clk_en stays 1. Writes are honoured only in run mode.
- R6: A run-mode write with pcon_wdata bit1 = 1 enters power-down, whatever bit0 holds. After that edge both cpu_clk_en and per_clk_en are 0.
- R7: In idle, irq_pend clears pcon_q to 00 on that edge. cpu_clk_en returns to 1 and irq_vec_req is high for that one clock. Writes in idle are ignored.
- R8: In power-down, irq_pend and writes are ignored. wake_ext clears pcon_q to 00, both enables return to 1 and irq_vec_req pulses once; the block does not enter idle.
- R9: An accepted reset, from the pin or from the watchdog, clears both power control bits and restores both clock enables.
- R10: While the synchronous block reset rst is high, pcon_q = 00, cpu_clk_en = per_clk_en = 1, and sys_rst, rst_drive and irq_vec_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin_in | input | 1 | Raw external reset request, active high, asynchronous |
| wdt_req | input | 1 | One-clock watchdog reset request |
| pcon_wr | input | 1 | Power control register write strobe |
| pcon_wdata | input | 2 | Write data: bit0 idle, bit1 power-down |
| irq_pend | input | 1 | Enabled pending interrupt |
| wake_ext | input | 1 | External interrupt wake for power-down |
| sys_rst | output | 1 | Internal system reset |
| rst_drive | output | 1 | Drive enable for the shared reset line |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pcon_q | output | 2 | Power control bits: bit0 idle, bit1 power-down |
| irq_vec_req | output | 1 | One-clock interrupt vector request on wake |

## Verification
The bench builds the block with QUAL_CLKS = 24, WDT_LEN = 96 and SYNC_STAGES = 2. With these values, random pin pulses of 1 to 40 clocks land on both sides of the acceptance threshold, including the 23 and 24 clock edge cases. A full 96-clock watchdog pulse, a retrigger partway through it, and the trailing sys_rst clock all fit in short runs. Random write, interrupt and wake sequences walk through every transition between run, idle and power-down.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_DOWN = 2'd2
  } pwr_mode_e;

  typedef struct packed {
    logic down;
    logic idle;
  } pctl_t;

  function automatic pwr_mode_e mode_of(pctl_t p);
    if (p.down) return MODE_DOWN;
    if (p.idle) return MODE_IDLE;
    return MODE_RUN;
  endfunction
endpackage

// File: rtl/rpc_rst_qual.sv
module rpc_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CLKS   = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL_CLKS);

  logic [SYNC_STAGES-1:0] sq;
  logic [CW-1:0]          cnt_q;
  logic                   lvl;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sq[0] <= 1'b0;
        else     sq[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sq[g] <= 1'b0;
        else     sq[g] <= sq[g-1];
      end
    end
  end

  assign lvl = sq[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || !lvl)      cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == FULL);

  // R1: acceptance only arrives from a count one short of full, with input still high
  assert_qual_window_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_o) |-> ($past(cnt_q) == CW'(QUAL_CLKS - 1)) && $past(lvl));
endmodule

// File: rtl/rpc_wdt_stretch.sv
module rpc_wdt_stretch #(
  parameter int WDT_LEN = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic drive_o
);
  localparam int WW = $clog2(WDT_LEN + 1);

  logic [WW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      drive_o <= 1'b0;
    end else if (req_i && !drive_o) begin
      left_q  <= WW'(WDT_LEN);
      drive_o <= 1'b1;
    end else if (left_q != '0) begin
      left_q  <= left_q - 1'b1;
      drive_o <= (left_q > WW'(1));
    end
  end

  logic [WW:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !drive_o) hi_cnt <= '0;
    else                 hi_cnt <= hi_cnt + 1'b1;
  end

  // R3: every drive pulse lasts exactly WDT_LEN clocks
  assert_pulse_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_o) |-> (hi_cnt == (WW+1)'(WDT_LEN)));
  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    drive_o |-> (hi_cnt < (WW+1)'(WDT_LEN)));
endmodule

// File: rtl/rpc_pmode.sv
module rpc_pmode
  import rpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       irq_i,
  input  logic       wake_i,
  output pctl_t      pctl_o,
  output logic       cpu_en_o,
  output logic       per_en_o,
  output logic       vec_o
);
  pctl_t     nxt;
  logic      wake_ev;
  pwr_mode_e cur;

  assign cur = mode_of(pctl_o);

  always_comb begin
    nxt     = pctl_o;
    wake_ev = 1'b0;
    if (clr_i) begin
      nxt = '0;
    end else begin
      unique case (cur)
        MODE_RUN:  if (wr_i) nxt = pctl_t'(wdata_i);
        MODE_IDLE: if (irq_i) begin nxt = '0; wake_ev = 1'b1; end
        MODE_DOWN: if (wake_i) begin nxt = '0; wake_ev = 1'b1; end
        default:   nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pctl_o   <= '0;
      cpu_en_o <= 1'b1;
      per_en_o <= 1'b1;
      vec_o    <= 1'b0;
    end else begin
      pctl_o   <= nxt;
      cpu_en_o <= !(nxt.idle || nxt.down);
      per_en_o <= !nxt.down;
      vec_o    <= wake_ev;
    end
  end

  // R6: power-down stops both clocks
  assert_down_gates_R6: assert property (@(posedge clk) disable iff (rst)
    pctl_o.down |-> (!cpu_en_o && !per_en_o));
  // R7: interrupt in idle restores the core clock and requests a vector
  assert_idle_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (!pctl_o.down && pctl_o.idle && irq_i && !clr_i) |=> (cpu_en_o && vec_o && !pctl_o.idle));
  // R8: power-down holds unless woken
  assert_down_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pctl_o.down && !wake_i && !clr_i) |=> pctl_o.down);
  // R9: accepted reset clears both control bits
  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pctl_o == '0) && cpu_en_o && per_en_o);
endmodule

// File: rtl/rst_pwr_ctrl.sv
module rst_pwr_ctrl
  import rpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CLKS   = 24,
  parameter int WDT_LEN     = 96
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_pin_in,
  input  logic       wdt_req,
  input  logic       pcon_wr,
  input  logic [1:0] pcon_wdata,
  input  logic       irq_pend,
  input  logic       wake_ext,
  output logic       sys_rst,
  output logic       rst_drive,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic [1:0] pcon_q,
  output logic       irq_vec_req
);
  logic  pin_ok;
  logic  acc_now;
  logic  acc_d;
  pctl_t pctl;

  rpc_rst_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_CLKS  (QUAL_CLKS)
  ) u_qual (
    .clk   (clk),
    .rst   (rst),
    .pin_i (rst_pin_in),
    .qual_o(pin_ok)
  );

  rpc_wdt_stretch #(
    .WDT_LEN(WDT_LEN)
  ) u_wdt (
    .clk    (clk),
    .rst    (rst),
    .req_i  (wdt_req),
    .drive_o(rst_drive)
  );

  assign acc_now = pin_ok || rst_drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_d   <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      acc_d   <= acc_now;
      sys_rst <= acc_now || acc_d;
    end
  end

  rpc_pmode u_pmode (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (acc_now),
    .wr_i    (pcon_wr),
    .wdata_i (pcon_wdata),
    .irq_i   (irq_pend),
    .wake_i  (wake_ext),
    .pctl_o  (pctl),
    .cpu_en_o(cpu_clk_en),
    .per_en_o(per_clk_en),
    .vec_o   (irq_vec_req)
  );

  assign pcon_q = pctl;

  // R2: system reset outlasts the accepted request by one clock
  assert_rst_tail_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(acc_now) |=> sys_rst);
  // R4: system reset follows the watchdog drive
  assert_wdt_sysrst_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_drive) |=> sys_rst);
endmodule

// File: tb/test_rst_pwr_ctrl.sv
`timescale 1ns/1ps
module test_rst_pwr_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_pin_in = 1'b0, wdt_req = 1'b0, pcon_wr = 1'b0;
  logic [1:0] pcon_wdata = 2'b00;
  logic irq_pend = 1'b0, wake_ext = 1'b0;
  logic sys_rst, rst_drive, cpu_clk_en, per_clk_en, irq_vec_req;
  logic [1:0] pcon_q;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_pwr_ctrl #(.SYNC_STAGES(2), .QUAL_CLKS(24), .WDT_LEN(96)) i_rst_pwr_ctrl (
    .clk(clk), .rst(rst), .rst_pin_in(rst_pin_in), .wdt_req(wdt_req),
    .pcon_wr(pcon_wr), .pcon_wdata(pcon_wdata), .irq_pend(irq_pend),
    .wake_ext(wake_ext), .sys_rst(sys_rst), .rst_drive(rst_drive),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pcon_q(pcon_q),
    .irq_vec_req(irq_vec_req));

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rst_len(int n);
    return (n >= 24) ? n - 22 : 0;
  endfunction

  // returns {vec, down, idle} after one clock
  function automatic logic [2:0] model(logic [1:0] p, logic wr, logic [1:0] d,
                                       logic irq, logic wk);
    if (p[1])      return wk  ? 3'b100 : {1'b0, p};
    else if (p[0]) return irq ? 3'b100 : {1'b0, p};
    else           return wr  ? {1'b0, d} : {1'b0, p};
  endfunction

  task automatic pin_pulse(int n, output int hi);
    hi = 0;
    @(negedge clk); rst_pin_in = 1'b1;
    for (int i = 0; i < n; i++) begin @(negedge clk); hi += int'(sys_rst); end
    rst_pin_in = 1'b0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); hi += int'(sys_rst); end
  endtask

  task automatic write_pcon(logic [1:0] d);
    @(negedge clk); pcon_wr = 1'b1; pcon_wdata = d;
    @(negedge clk); pcon_wr = 1'b0; pcon_wdata = 2'b00;
  endtask

  initial begin
    int hi, dr, len;
    logic [1:0] p;
    logic [2:0] e;
    logic [1:0] d;
    logic wr, irq, wk;
    string tag;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 pcon", int'(pcon_q), 0);
    check("R10 cpu_en", int'(cpu_clk_en), 1);
    check("R10 per_en", int'(per_clk_en), 1);
    check("R10 sys_rst", int'(sys_rst), 0);
    check("R10 drive", int'(rst_drive), 0);
    check("R10 vec", int'(irq_vec_req), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R2 directed edges
    pin_pulse(23, hi); check("R1 pulse 23 ignored", hi, 0);
    pin_pulse(24, hi); check("R2 pulse 24", hi, exp_rst_len(24));
    pin_pulse(1, hi);  check("R1 pulse 1 ignored", hi, 0);
    for (int k = 0; k < 12; k++) begin
      len = 1 + int'($urandom_range(0, 39));
      pin_pulse(len, hi);
      check(len >= 24 ? "R2 random pulse" : "R1 random pulse", hi, exp_rst_len(len));
    end

    // R3 / R4 watchdog with a retrigger attempt
    hi = 0; dr = 0;
    @(negedge clk); wdt_req = 1'b1;
    @(negedge clk); wdt_req = 1'b0;
    dr += int'(rst_drive); hi += int'(sys_rst);
    for (int i = 0; i < 140; i++) begin
      if (i == 40) wdt_req = 1'b1; else wdt_req = 1'b0;
      @(negedge clk);
      dr += int'(rst_drive); hi += int'(sys_rst);
    end
    wdt_req = 1'b0;
    check("R3 drive length, retrigger ignored", dr, 96);
    check("R4 sys_rst length", hi, 97);

    // R5 idle entry, R7 exit
    write_pcon(2'b01);
    check("R5 idle bits", int'(pcon_q), 1);
    check("R5 cpu_en", int'(cpu_clk_en), 0);
    check("R5 per_en", int'(per_clk_en), 1);
    write_pcon(2'b10);
    check("R7 write in idle ignored", int'(pcon_q), 1);
    irq_pend = 1'b1; @(negedge clk); irq_pend = 1'b0;
    check("R7 idle cleared", int'(pcon_q), 0);
    check("R7 cpu_en", int'(cpu_clk_en), 1);
    check("R7 vec pulse", int'(irq_vec_req), 1);
    @(negedge clk);
    check("R7 vec one clock", int'(irq_vec_req), 0);

    // R6 both bits, R8 irq ignored then wake
    write_pcon(2'b11);
    check("R6 down bits", int'(pcon_q), 3);
    check("R6 enables", int'({cpu_clk_en, per_clk_en}), 0);
    irq_pend = 1'b1; @(negedge clk); irq_pend = 1'b0;
    check("R8 irq ignored", int'(pcon_q), 3);
    check("R8 no vec", int'(irq_vec_req), 0);
    wake_ext = 1'b1; @(negedge clk); wake_ext = 1'b0;
    check("R8 wake clears, no idle", int'(pcon_q), 0);
    check("R8 enables", int'({cpu_clk_en, per_clk_en}), 3);
    check("R8 vec", int'(irq_vec_req), 1);

    // R9 pin reset leaves power-down, watchdog leaves idle
    write_pcon(2'b10);
    check("R6 down only", int'(per_clk_en), 0);
    pin_pulse(30, hi);
    check("R9 pin clears down", int'(pcon_q), 0);
    check("R9 enables", int'({cpu_clk_en, per_clk_en}), 3);
    write_pcon(2'b01);
    @(negedge clk); wdt_req = 1'b1; @(negedge clk); wdt_req = 1'b0;
    @(negedge clk);
    check("R9 wdt clears idle", int'(pcon_q), 0);
    repeat (100) @(negedge clk);

    // random mode walk
    p = pcon_q;
    for (int k = 0; k < 400; k++) begin
      wr  = ($urandom_range(0, 3) == 0);
      d   = 2'($urandom_range(0, 3));
      irq = ($urandom_range(0, 3) == 0);
      wk  = ($urandom_range(0, 7) == 0);
      e = model(p, wr, d, irq, wk);
      tag = p[1] ? "R8 random" : (p[0] ? "R7 random" : (d[1] ? "R6 random" : "R5 random"));
      pcon_wr = wr; pcon_wdata = d; irq_pend = irq; wake_ext = wk;
      @(negedge clk);
      check(tag, int'({irq_vec_req, pcon_q}), int'(e));
      check(tag, int'({cpu_clk_en, per_clk_en}),
            int'({~(e[1] | e[0]), ~e[1]}));
      p = e[1:0];
    end
    pcon_wr = 1'b0; irq_pend = 1'b0; wake_ext = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule